// File: doc/BRIEF.md
# Operand Bus Sequencer

This block links a processor-side operand request to a 16-bit external data bus. A request gives an address, an operand size (byte, word or long word), a direction and up to 32 bits of right-justified write data. The block first checks alignment. It then runs one or two bus cycles. Each cycle drives the address, a code for the number of bytes still to be moved, and the write data placed on the correct byte lanes.

On reads, the returned lanes are gathered into a right-justified 32-bit result. Each bus cycle is held until the bus side acknowledges it. A word or long word at an odd address is refused. For such a request the block raises a single-clock error pulse and starts no bus cycle at all.

Top module: `opnd_bus_seq`

## Requirements
- R1: After reset, `ready` is 1, and `bus_cyc`, `done` and `addr_err` are 0.
- R2: A request is taken on a rising clock edge where `req_valid` and `ready` are both 1. If the request is a word or long word (`req_size` other than 00) and `req_addr[0]` is 1, then `addr_err` is 1 for exactly the following clock, no bus cycle starts, and `ready` stays 1.
- R3: A byte request (`req_size` = 00) is valid at any address. It runs a single bus cycle with `bus_addr` equal to the request address and `bus_siz` = 01.
- R4: A word request (`req_size` = 01, and also 11) at an even address runs a single bus cycle with `bus_siz` = 10 and `bus_addr` equal to the request address.
- R5: A long-word request (`req_size` = 10) runs exactly two consecutive bus cycles:
  - The first cycle uses the request address with `bus_siz` = 00 and carries write bits 31:16.
  - The second cycle uses the request address plus 2, wrapping modulo 2^AW, with `bus_siz` = 10 and carries write bits 15:0.
- R6: On a write, the lanes carry the data as follows:
  - A word places write bits 15:0 on `bus_wdata`.
  - A byte places write bits 7:0 on both lanes, bits 15:8 and bits 7:0.
- R7: On a read, `rdata` holds the result from `done` onward:
  - A byte takes lane 15:8 at an even address or lane 7:0 at an odd address, zero-extended.
  - A word is `bus_rdata` zero-extended.
  - A long word is {first-cycle data, second-cycle data}.
- R8: A bus cycle keeps `bus_cyc`, `bus_addr`, `bus_siz` and `bus_wdata` unchanged until the clock on which `bus_ack` is sampled high.
- R9: `done` is 1 for exactly the one clock that follows the edge sampling the last `bus_ack` of a request. While a request is in progress, `ready` is 0 and `req_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | AW | Operand byte address |
| req_size | input | 2 | 00 byte, 01/11 word, 10 long word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Right-justified write operand |
| ready | output | 1 | Idle, request can be taken |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_addr | output | AW | Cycle address (bit 0 is byte offset) |
| bus_siz | output | 2 | Bytes remaining: 01 one, 10 two, 11 three, 00 four |
| bus_write | output | 1 | Cycle direction |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read data from the bus |
| bus_ack | input | 1 | Cycle acknowledge |
| done | output | 1 | One-clock completion strobe |
| rdata | output | 32 | Assembled read operand |
| addr_err | output | 1 | One-clock misalignment strobe |

## Verification
The bench builds the block with its default address width of 24 bits. At that width, a long word at 0xFFFFFE is within reach, so the second cycle's wrap to address 0 is exercised. Acknowledge delays of zero to four clocks are used to check that each cycle is held. Both byte offsets are run for byte reads and writes, so each lane is selected in turn.

// File: rtl/opnd_bus_seq.sv
module opnd_bus_seq #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  output logic          ready,
  output logic          bus_cyc,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_siz,
  output logic          bus_write,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata,
  input  logic          bus_ack,
  output logic          done,
  output logic [31:0]   rdata,
  output logic          addr_err
);

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_LONG = 2'b10;

  logic          busy, second, we_q, done_q, err_q;
  logic [AW-1:0] a_q;
  logic [1:0]    sz_q;
  logic [31:0]   wd_q, rd_q;

  wire take     = req_valid && !busy;
  wire misalign = (req_size != SZ_BYTE) && req_addr[0];
  wire is_byte  = (sz_q == SZ_BYTE);
  wire long_hi  = (sz_q == SZ_LONG) && !second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      second <= 1'b0;
      we_q   <= 1'b0;
      a_q    <= '0;
      sz_q   <= SZ_BYTE;
      wd_q   <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (take) begin
        if (misalign) begin
          err_q <= 1'b1;
        end else begin
          busy   <= 1'b1;
          second <= 1'b0;
          a_q    <= req_addr;
          sz_q   <= req_size;
          we_q   <= req_write;
          wd_q   <= req_wdata;
        end
      end else if (busy && bus_ack) begin
        if (!we_q) begin
          if (is_byte)
            rd_q <= {24'h0, a_q[0] ? bus_rdata[7:0] : bus_rdata[15:8]};
          else if (long_hi)
            rd_q[31:16] <= bus_rdata;
          else if (sz_q == SZ_LONG)
            rd_q[15:0] <= bus_rdata;
          else
            rd_q <= {16'h0, bus_rdata};
        end
        if (long_hi) begin
          second <= 1'b1;
          a_q    <= a_q + AW'(2);
        end else begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign ready     = !busy;
  assign bus_cyc   = busy;
  assign bus_addr  = a_q;
  assign bus_write = we_q;
  assign bus_siz   = is_byte ? 2'b01 : (long_hi ? 2'b00 : 2'b10);
  assign bus_wdata = is_byte ? {wd_q[7:0], wd_q[7:0]} : (long_hi ? wd_q[31:16] : wd_q[15:0]);
  assign done      = done_q;
  assign rdata     = rd_q;
  assign addr_err  = err_q;

  p_misalign_no_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready && (req_size != 2'b00) && req_addr[0]) |=> (addr_err && !bus_cyc))
    else $error("p_misalign_no_cycle_r2");

  p_even_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_siz != 2'b01) |-> !bus_addr[0])
    else $error("p_even_wide_r4");

  p_long_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack && bus_siz == 2'b00) |=>
      (bus_cyc && bus_siz == 2'b10 && (bus_addr - $past(bus_addr)) == AW'(2)))
    else $error("p_long_second_r5");

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_ack) |=>
      (bus_cyc && $stable(bus_addr) && $stable(bus_siz) && $stable(bus_wdata)))
    else $error("p_hold_r8");

  p_done_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_cyc && bus_ack))
    else $error("p_done_after_ack_r9");

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("p_done_pulse_r9");

endmodule

// File: tb/opnd_bus_seq_bench.sv
module opnd_bus_seq_bench;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [23:0] req_addr = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] req_wdata = 0;
  logic        ready, bus_cyc, bus_write, done, addr_err;
  logic [23:0] bus_addr;
  logic [1:0]  bus_siz;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_ack;
  logic [31:0] rdata;

  opnd_bus_seq #(.AW(24)) u_opnd_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .ready(ready), .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_siz(bus_siz),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .done(done), .rdata(rdata), .addr_err(addr_err));

  always #5 clk = ~clk;

  typedef struct { logic [23:0] a; logic [1:0] s; logic w; logic [15:0] wd; logic [15:0] rd; } bus_t;
  typedef struct { logic err; logic rd_chk; logic [31:0] rd; } res_t;

  bus_t exp_bus[$];
  res_t exp_res[$];
  int nchk = 0, nfail = 0, cyc = 0, evt_cyc = 0, wait_n = 0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic expect_req(input logic [1:0] sz, input logic [23:0] a, input logic w,
                            input logic [31:0] wd, input logic [15:0] rhi, input logic [15:0] rlo);
    bus_t b;
    res_t r;
    r.err = 0; r.rd_chk = !w; r.rd = 0;
    if (sz != 2'b00 && a[0]) begin
      r.err = 1; r.rd_chk = 0;
    end else if (sz == 2'b00) begin
      b = '{a, 2'b01, w, {wd[7:0], wd[7:0]}, rlo};
      exp_bus.push_back(b);
      r.rd = {24'h0, a[0] ? rlo[7:0] : rlo[15:8]};
    end else if (sz == 2'b10) begin
      b = '{a, 2'b00, w, wd[31:16], rhi};
      exp_bus.push_back(b);
      b = '{a + 24'd2, 2'b10, w, wd[15:0], rlo};
      exp_bus.push_back(b);
      r.rd = {rhi, rlo};
    end else begin
      b = '{a, 2'b10, w, wd[15:0], rlo};
      exp_bus.push_back(b);
      r.rd = {16'h0, rlo};
    end
    exp_res.push_back(r);
  endtask

  task automatic drive(input logic [1:0] sz, input logic [23:0] a, input logic w, input logic [31:0] wd);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_size = sz; req_addr = a; req_write = w; req_wdata = wd; req_valid = 1;
    evt_cyc = cyc + 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (exp_res.size() != 0) @(negedge clk);
    @(negedge clk);
    check(exp_bus.size() == 0, "R5", "leftover bus cycles", exp_bus.size(), 0);
  endtask

  task automatic do_req(input logic [1:0] sz, input logic [23:0] a, input logic w,
                        input logic [31:0] wd, input logic [15:0] rhi, input logic [15:0] rlo);
    expect_req(sz, a, w, wd, rhi, rlo);
    drive(sz, a, w, wd);
    drain();
  endtask

  initial begin
    bus_t cur;
    res_t r;
    int wcnt;
    bit in_cyc;
    bus_ack = 0; bus_rdata = 0; in_cyc = 0; wcnt = 0;
    cur = '{0, 0, 0, 0, 0};
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (bus_ack) begin bus_ack = 0; in_cyc = 0; end
      if (done || addr_err) begin
        if (exp_res.size() == 0) begin
          check(0, "R9", "unexpected done/addr_err", {30'h0, done, addr_err}, 0);
        end else begin
          r = exp_res.pop_front();
          check(addr_err == r.err, r.err ? "R2" : "R9", "result kind (addr_err)", addr_err, r.err);
          check(cyc == evt_cyc, r.err ? "R2" : "R9", "strobe clock", cyc, evt_cyc);
          if (r.err) check(ready == 1, "R2", "ready after error", ready, 1);
          if (done && r.rd_chk) check(rdata == r.rd, "R7", "read operand", rdata, r.rd);
        end
      end
      if (bus_cyc) begin
        if (!in_cyc) begin
          if (exp_bus.size() == 0) begin
            check(0, "R2", "unexpected bus cycle", bus_addr, 0);
          end else begin
            cur = exp_bus.pop_front();
            check(bus_addr == cur.a, "R3", "bus_addr", bus_addr, cur.a);
            check(bus_siz == cur.s, "R4", "bus_siz", bus_siz, cur.s);
            check(bus_write == cur.w, "R5", "bus_write", bus_write, cur.w);
            if (cur.w) check(bus_wdata == cur.wd, "R6", "bus_wdata", bus_wdata, cur.wd);
          end
          in_cyc = 1; wcnt = 0;
        end else begin
          check(bus_addr == cur.a && bus_siz == cur.s, "R8", "held cycle", {bus_siz, 6'h0, bus_addr}, {cur.s, 6'h0, cur.a});
          check(ready == 0, "R9", "ready while busy", ready, 0);
        end
        if (wcnt >= wait_n) begin
          bus_ack = 1; bus_rdata = cur.rd; evt_cyc = cyc + 1;
        end else wcnt++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "R9", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ready == 1 && bus_cyc == 0 && done == 0 && addr_err == 0, "R1", "reset state",
          {ready, bus_cyc, done, addr_err}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    check(ready == 1 && bus_cyc == 0, "R1", "idle after reset", {ready, bus_cyc}, 2'b10);

    wait_n = 0; do_req(2'b00, 24'h000100, 1, 32'hDEAD_BEA5, 0, 0);        // R3 R6 even byte
    wait_n = 1; do_req(2'b00, 24'h000101, 1, 32'h0000_003C, 0, 0);        // R3 R6 odd byte
    wait_n = 0; do_req(2'b00, 24'h000200, 0, 0, 0, 16'hA1B2);             // R7 lane 15:8
    wait_n = 2; do_req(2'b00, 24'h000203, 0, 0, 0, 16'hC3D4);             // R7 lane 7:0
    wait_n = 2; do_req(2'b01, 24'h001234, 1, 32'h5555_9876, 0, 0);        // R4 R6 word
    wait_n = 0; do_req(2'b01, 24'h001236, 0, 0, 0, 16'h8001);             // R4 R7 word read
    wait_n = 1; do_req(2'b11, 24'h00400A, 1, 32'h0000_F00D, 0, 0);        // R4 size 11
    wait_n = 3; do_req(2'b10, 24'h0ABC10, 1, 32'h1122_3344, 0, 0);        // R5 long write
    wait_n = 0; do_req(2'b10, 24'h0ABC20, 0, 0, 16'hCAFE, 16'hBABE);      // R5 R7 long read
    wait_n = 1; do_req(2'b10, 24'hFFFFFE, 0, 0, 16'h0F0F, 16'hF0F0);      // R5 wrap
    wait_n = 0; do_req(2'b01, 24'h000301, 1, 32'h1234_5678, 0, 0);        // R2 word odd
    wait_n = 0; do_req(2'b10, 24'h000305, 0, 0, 0, 0);                    // R2 long odd
    wait_n = 0; do_req(2'b00, 24'h000305, 0, 0, 0, 16'h00EE);             // R3 odd byte legal

    // R9: request during a busy long word must be ignored
    wait_n = 4;
    expect_req(2'b10, 24'h002000, 0, 0, 16'h1357, 16'h2468);
    drive(2'b10, 24'h002000, 0, 0);
    check(ready == 0, "R9", "ready low while busy", ready, 0);
    req_size = 2'b01; req_addr = 24'h000011; req_write = 1; req_valid = 1;
    repeat (2) @(negedge clk);
    req_valid = 0;
    drain();

    report();
  end
endmodule